// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial memory slave. It gathers the data bytes of one write transfer into a 32-byte page buffer. After a valid stop, it copies those bytes into the memory array during an internally timed write cycle. The serial slave gives it three things. An address-load pulse carries the start word address. A byte strobe arrives for each received data byte. Separate strobes report start and stop conditions. A write-protect input decides whether a stop may commit anything at all.

Only the low five bits of the word pointer advance as bytes arrive, so a transfer never leaves its page. Bytes beyond the 32nd land on positions that were already filled, and the later byte replaces the earlier one. While the timed cycle runs, the block raises `busy`. The slave withholds its device-address acknowledge for as long as `busy` is high, and a master can use this to poll for completion. The block ignores every strobe during that time. The length of the cycle is `TWR_CYC` system clock cycles. Inside that cycle, the block walks the 32 positions in ascending order, one per clock. It writes to the array only the positions that the transfer filled. The other bytes of the page keep their stored values.

The controller has four states:
- `ST_IDLE` waits for an address load.
- `ST_FILL` collects bytes.
- `ST_FLUSH` scans the buffer into the array.
- `ST_HOLD` waits out the rest of the timed cycle.

The transitions are:
- `ST_IDLE` goes to `ST_FILL` on an address load.
- `ST_FILL` goes to `ST_FLUSH` on a stop with at least one byte buffered and write protect low.
- `ST_FILL` goes to `ST_IDLE` on a start, or on a stop that is protected or has no bytes.
- `ST_FLUSH` goes to `ST_HOLD` after the last position is scanned.
- `ST_HOLD` goes to `ST_IDLE` when the cycle timer expires.
- `ST_FLUSH` goes directly to `ST_IDLE` only if the timer expires on the last scan position.

Top module: `pwb_commit`

## Requirements
- R1: After reset, `busy` is 0, `arr_we` is 0 and `cur_addr` is 0.
- R2: An address load sets `cur_addr` to `addr_in`. Each accepted byte is buffered at position `cur_addr[4:0]`. After that byte, `cur_addr[4:0]` increments modulo 32 and `cur_addr[12:5]` is unchanged.
- R3: When more than 32 bytes arrive in one transfer, the pointer wraps within the page. Each position holds the last byte sent to it, and the commit writes each position at most once.
- R4: A stop with at least one buffered byte and `wp` low raises `busy` on the clock edge that samples the stop. `busy` then stays high for exactly `TWR_CYC` cycles.
- R5: During `busy`, the block writes to the array only the positions filled in the transfer, in ascending address order, all inside the current page. Other array bytes are unchanged.
- R6: If `wp` is high when the stop is sampled, there is no array write and no `busy`, and the buffer is discarded.
- R7: A stop with no buffered bytes (address load only) causes neither `busy` nor array writes. `cur_addr` keeps the loaded address.
- R8: A start strobe before the stop discards the buffered bytes. A following stop writes nothing.
- R9: While `busy` is high, address loads, byte strobes, start and stop strobes have no effect. `cur_addr` holds, and no such byte reaches the array.
- R10: After a commit, `cur_addr` equals the last written address plus one, wrapped within the page.
- R11: A byte strobe with no preceding address load is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp | input | 1 | Write protect; sampled together with the stop strobe |
| addr_load | input | 1 | Pulse: load the start word address |
| addr_in | input | AW | Start word address |
| byte_stb | input | 1 | Pulse: a data byte was received |
| byte_in | input | 8 | Received data byte |
| start_stb | input | 1 | Pulse: start condition seen |
| stop_stb | input | 1 | Pulse: stop condition seen |
| busy | output | 1 | Timed write cycle in progress; device address must not be acknowledged |
| cur_addr | output | AW | Persistent word address pointer |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The main function is tried with several transfer shapes:
- a single byte at the page start;
- a full 32 bytes from the middle of a page, which separates a pointer that wraps within the page from one that carries into the next page;
- a short run across the top of the address space;
- 40 bytes, which separates overwrite-in-place from spill-over.

A protected stop and a stop after an address load alone separate "commit" from "discard". A short rewrite of a page that already holds data separates the write of only the filled positions from a write of the whole page. Strobes issued while `busy` is high, and a start before the stop, show that the buffer and the pointer are isolated at those times.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_HOLD  = 2'd3
    } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
// Page staging storage: one byte and one "filled" flag per position.
module pwb_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int IW = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic          any_valid
);
    logic [7:0]            mem [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld <= '0;
        else if (clr)   vld <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_comb begin
        rd_data   = mem[rd_idx];
        rd_valid  = vld[rd_idx];
        any_valid = |vld;
    end
endmodule

// File: rtl/pwb_timer.sv
// Counts cycles while run is high; last marks the final cycle of the window.
module pwb_timer #(
    parameter int CYC = 64,
    localparam int CW = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign last = run && (cnt == CW'(CYC - 1));
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
    import pwb_pkg::*;
#(
    parameter int AW         = 13,
    parameter int PAGE_BYTES = 32,
    parameter int TWR_CYC    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wp,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          byte_stb,
    input  logic [7:0]    byte_in,
    input  logic          start_stb,
    input  logic          stop_stb,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_wdata
);
    localparam int IW = $clog2(PAGE_BYTES);

    pwb_state_e    state, state_nx;
    logic [AW-1:0] ptr;
    logic [IW-1:0] scan_idx;
    logic          rx_open, ld, take, commit_ok, tdone, buf_clr;
    logic [7:0]    rd_data;
    logic          rd_valid, any_valid;

    // Accept decodes; stop and start outrank address load, which outranks bytes.
    always_comb begin
        rx_open   = (state == ST_IDLE) || (state == ST_FILL);
        ld        = rx_open && addr_load && !start_stb && !stop_stb;
        take      = (state == ST_FILL) && byte_stb && !addr_load && !start_stb && !stop_stb;
        commit_ok = any_valid && !wp;
        buf_clr   = (rx_open && (start_stb || addr_load))
                 || ((state == ST_FILL) && stop_stb && !commit_ok)
                 || (busy && tdone);
    end

    pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (take),
        .wr_idx   (ptr[IW-1:0]),
        .wr_data  (byte_in),
        .clr      (buf_clr),
        .rd_idx   (scan_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .any_valid(any_valid)
    );

    pwb_timer #(.CYC(TWR_CYC)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .last (tdone)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ld) state_nx = ST_FILL;
            ST_FILL: begin
                if (stop_stb)       state_nx = commit_ok ? ST_FLUSH : ST_IDLE;
                else if (start_stb) state_nx = ST_IDLE;
            end
            ST_FLUSH: begin
                if (tdone)                         state_nx = ST_IDLE;
                else if (&scan_idx)                state_nx = ST_HOLD;
            end
            ST_HOLD:  if (tdone) state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Scan index and persistent pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx <= '0;
            ptr      <= '0;
        end else begin
            scan_idx <= (state == ST_FLUSH) ? scan_idx + 1'b1 : '0;
            if (ld)
                ptr <= addr_in;
            else if (take)
                ptr <= {ptr[AW-1:IW], ptr[IW-1:0] + 1'b1};
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_FLUSH) || (state == ST_HOLD);
        arr_we    = (state == ST_FLUSH) && rd_valid;
        arr_addr  = {ptr[AW-1:IW], scan_idx};
        arr_wdata = rd_data;
        cur_addr  = ptr;
    end
endmodule

// File: rtl/pwb_commit_chk.sv
module pwb_commit_chk #(
    parameter int AW         = 13,
    parameter int PAGE_BYTES = 32,
    parameter int TWR_CYC    = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wp,
    input logic          stop_stb,
    input logic          busy,
    input logic [AW-1:0] cur_addr,
    input logic          arr_we,
    input logic [AW-1:0] arr_addr
);
    localparam int IW = $clog2(PAGE_BYTES);

    int   bcnt;
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt   <= 0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= busy;
            if (busy && !busy_q) bcnt <= 1;
            else if (busy)       bcnt <= bcnt + 1;
        end
    end

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb)); // R4
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == TWR_CYC)); // R4
    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R5
    AST_WRITE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr > $past(arr_addr))); // R5
    AST_WRITE_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[AW-1:IW] == $past(arr_addr[AW-1:IW]))); // R2
    AST_PROTECT_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && wp && !busy) |=> !busy); // R6
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr)); // R9
endmodule

bind pwb_commit pwb_commit_chk #(
    .AW(AW), .PAGE_BYTES(PAGE_BYTES), .TWR_CYC(TWR_CYC)
) u_chk (.*);

// File: tb/test_pwb_commit.sv
module test_pwb_commit;
    localparam int AW  = 13;
    localparam int TWR = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp = 1'b0, addr_load = 1'b0, byte_stb = 1'b0;
    logic          start_stb = 1'b0, stop_stb = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    byte_in = '0;
    logic          busy, arr_we;
    logic [AW-1:0] cur_addr, arr_addr;
    logic [7:0]    arr_wdata;

    int checks = 0, failures = 0;
    int wr_cnt = 0, ord_err = 0;
    logic [7:0]    cap   [0:(1<<AW)-1];
    logic [7:0]    model [0:(1<<AW)-1];
    logic          prev_v = 1'b0;
    logic [AW-1:0] prev_a = '0;

    always #2.5 clk = ~clk;

    pwb_commit #(.AW(AW), .PAGE_BYTES(32), .TWR_CYC(TWR)) i_pwb_commit (
        .clk(clk), .rst_n(rst_n), .wp(wp), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .start_stb(start_stb), .stop_stb(stop_stb),
        .busy(busy), .cur_addr(cur_addr), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata)
    );

    // Array port monitor: captures writes and checks ascending order (R5)
    always @(posedge clk) begin
        if (rst_n && arr_we) begin
            cap[arr_addr] <= arr_wdata;
            wr_cnt <= wr_cnt + 1;
            if (prev_v && arr_addr <= prev_a) ord_err <= ord_err + 1;
            prev_v <= 1'b1;
            prev_a <= arr_addr;
        end else if (!busy) begin
            prev_v <= 1'b0;
        end
    end

    // rows: {start address, byte count, first data value, wp}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {13'h0000, 6'd1,  8'h11, 1'b0},
        {13'h0105, 6'd32, 8'h20, 1'b0},
        {13'h1FFE, 6'd5,  8'h40, 1'b0},
        {13'h0040, 6'd40, 8'h60, 1'b0},
        {13'h0300, 6'd7,  8'h80, 1'b1},
        {13'h0300, 6'd3,  8'h90, 1'b0},
        {13'h0410, 6'd0,  8'h00, 1'b0},
        {13'h0105, 6'd2,  8'hC0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_load(input logic [AW-1:0] a);
        addr_in = a; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
    endtask
    task automatic pulse_byte(input logic [7:0] b);
        byte_in = b; byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
    endtask
    task automatic pulse_stop();
        stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    endtask
    task automatic pulse_start();
        start_stb = 1'b1; @(negedge clk); start_stb = 1'b0;
    endtask

    // Called at the negedge right after the stop pulse; counts busy cycles.
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < TWR + 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic compare_page(input logic [AW-1:0] a, input string req);
        int mism = 0;
        for (int p = 0; p < 32; p++) begin
            if (cap[{a[AW-1:5], 5'(p)}] !== model[{a[AW-1:5], 5'(p)}]) mism++;
        end
        check(mism == 0, req, mism, 0);
    endtask

    task automatic run_row(input logic [AW-1:0] a, input int n, input logic [7:0] seed, input logic w);
        int bc;
        int w0;
        int exp_w;
        string tag;
        w0 = wr_cnt;
        wp = w;
        pulse_load(a);
        for (int i = 0; i < n; i++) begin
            pulse_byte(seed + 8'(i));
            if (!w) model[{a[AW-1:5], 5'(a[4:0] + i)}] = seed + 8'(i);
        end
        pulse_stop();
        count_busy(bc);
        wp = 1'b0;
        @(negedge clk);
        tag = w ? "R6" : (n == 0 ? "R7" : (n > 32 ? "R3" : "R4"));
        check(bc == ((n > 0 && !w) ? TWR : 0), tag, bc, (n > 0 && !w) ? TWR : 0);
        exp_w = (w || n == 0) ? 0 : (n > 32 ? 32 : n);
        check(wr_cnt - w0 == exp_w, {tag, " R5 write count"}, wr_cnt - w0, exp_w);
        compare_page(a, {tag, " R5 page contents"});
        check(cur_addr == {a[AW-1:5], 5'(a[4:0] + n)}, "R2 R10 pointer", cur_addr,
              {a[AW-1:5], 5'(a[4:0] + n)});
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int bc;
        int w0;
        for (int k = 0; k < (1 << AW); k++) begin
            cap[k] = 8'h00;
            model[k] = 8'h00;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0 && arr_we == 1'b0, "R1 busy/we", {busy, arr_we}, 0);
        check(cur_addr == '0, "R1 pointer", cur_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: bytes without an address load are dropped
        pulse_byte(8'hEE);
        pulse_byte(8'hEF);
        pulse_stop();
        count_busy(bc);
        check(bc == 0 && wr_cnt == 0, "R11 no commit", bc + wr_cnt, 0);
        check(cur_addr == '0, "R11 pointer", cur_addr, 0);

        // Table-driven transfers
        for (int v = 0; v < NV; v++) begin
            run_row(VEC[v][27:15], int'(VEC[v][14:9]), VEC[v][8:1], VEC[v][0]);
        end

        // R8: start before stop discards the buffer
        w0 = wr_cnt;
        pulse_load(13'h0500);
        pulse_byte(8'h01);
        pulse_byte(8'h02);
        pulse_byte(8'h03);
        pulse_start();
        pulse_stop();
        count_busy(bc);
        check(bc == 0, "R8 no busy", bc, 0);
        check(wr_cnt == w0, "R8 no writes", wr_cnt - w0, 0);
        check(cur_addr == 13'h0503, "R8 pointer", cur_addr, 13'h0503);

        // R9: strobes during busy are ignored
        w0 = wr_cnt;
        pulse_load(13'h0600);
        pulse_byte(8'hA1);
        pulse_byte(8'hA2);
        model[13'h0600] = 8'hA1;
        model[13'h0601] = 8'hA2;
        pulse_stop();
        repeat (3) @(negedge clk);
        pulse_load(13'h0700);
        pulse_byte(8'h5A);
        pulse_start();
        pulse_stop();
        check(busy == 1'b1, "R9 still busy", busy, 1);
        check(cur_addr == 13'h0602, "R9 pointer frozen", cur_addr, 13'h0602);
        count_busy(bc);
        @(negedge clk);
        check(wr_cnt - w0 == 2, "R9 write count", wr_cnt - w0, 2);
        compare_page(13'h0600, "R9 page contents");
        check(cap[13'h0700] == 8'h00, "R9 stray byte", cap[13'h0700], 0);
        pulse_stop();
        count_busy(bc);
        check(bc == 0, "R9 no later commit", bc, 0);

        check(ord_err == 0, "R5 ascending order", ord_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule